// File: doc/BRIEF.md
# Edge-Selectable Event Interrupt Generator

This block watches a single event line that belongs to another clock domain, for example a PHY error flag or an end-of-frame marker from a sensor front end. It brings that line into the host clock domain through a chain of synchronizer flops. It then compares the synchronized level with its value one cycle earlier. When the edge type that software has chosen appears, the block raises a one-cycle interrupt request. A downstream message generator turns that request into an interrupt message for the host.

Software picks the active edge type with a 2-bit mode input. The choices are rising only, falling only, both, or none. Because the event line is sampled asynchronously, each level must last at least two host clock cycles to be seen. The request output is a plain control pulse, not a stream. It carries no payload and has no ready input, so there is no back-pressure: the consumer must capture every pulse in the cycle in which it is high.

After reset the synchronizer fills with the current event level, and edge detection is held off until it has filled. An event line that is already high when reset is released is therefore never reported as an edge.

Top module: `sensor_evt_irq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `irq_pulse` stays low unless the event line changes level. A level that is already present at reset release is not reported as an edge.
- R2: With `edge_sel` = 2'b01 (rising), a 0-to-1 change of `evt_async` gives exactly one pulse, and a 1-to-0 change gives none.
- R3: With `edge_sel` = 2'b10 (falling), a 1-to-0 change gives exactly one pulse, and a 0-to-1 change gives none.
- R4: With `edge_sel` = 2'b11 (both), every change of level gives exactly one pulse.
- R5: With `edge_sel` = 2'b00 (off), no change of level gives a pulse.
- R6: With the default of two synchronizer stages, the pulse is high for exactly one cycle. It follows the third rising `clk` edge, counting the first edge that samples the new level as the first.
- R7: While `evt_async` holds a steady level, no further pulses appear, however long the level lasts.
- R8: A level held for only two host cycles is still detected. Under mode 2'b11, a two-cycle high pulse on `evt_async` gives two request pulses two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset, host domain |
| evt_async | input | 1 | Event line from the sensor clock domain |
| edge_sel | input | 2 | Edge mode: 00 off, 01 rising, 10 falling, 11 both |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The bench holds the event line high through reset and then releases reset. A design that compared against an unfilled synchronizer would report a false rising edge here. It steps through all four modes, once for each direction of change, and checks both the number of pulses and the cycle in which each appears. A wrongly decoded mode or a swapped edge shows up as a missing or extra pulse. An extra register stage shows up as a pulse in the wrong cycle. A two-cycle event pulse then checks that the minimum legal width is caught in both directions. A long steady level checks that a level-sensitive design, which would fire repeatedly, is caught.

// File: rtl/sensor_evt_pkg.sv
package sensor_evt_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/sensor_evt_sync.sv
module sensor_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync,
  output logic q_ok
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] filled;

  // One data flop and one fill marker per stage; the marker tells the
  // detector when the chain holds a real sample rather than reset value.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            chain[i]  <= 1'b0;
            filled[i] <= 1'b0;
          end else begin
            chain[i]  <= d_async;
            filled[i] <= 1'b1;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            chain[i]  <= 1'b0;
            filled[i] <= 1'b0;
          end else begin
            chain[i]  <= chain[i-1];
            filled[i] <= filled[i-1];
          end
        end
      end
    end
  endgenerate

  assign q_sync = chain[LAST];
  assign q_ok   = filled[LAST];

endmodule

// File: rtl/sensor_evt_edge.sv
module sensor_evt_edge
  import sensor_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic       lvl_ok,
  input  edge_mode_e mode,
  output logic       lvl_prev,
  output logic       pulse
);
  logic prev_ok;
  logic rise_seen;
  logic fall_seen;
  logic hit;

  // The previous-level register only arms once it has taken a real sample,
  // so the first value after reset is absorbed without reporting an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_prev <= 1'b0;
      prev_ok  <= 1'b0;
    end else if (lvl_ok) begin
      lvl_prev <= lvl;
      prev_ok  <= 1'b1;
    end
  end

  assign rise_seen = prev_ok & lvl_ok &  lvl & ~lvl_prev;
  assign fall_seen = prev_ok & lvl_ok & ~lvl &  lvl_prev;

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = rise_seen;
      EDGE_FALL: hit = fall_seen;
      EDGE_BOTH: hit = rise_seen | fall_seen;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= hit;
  end

endmodule

// File: rtl/sensor_evt_irq.sv
module sensor_evt_irq
  import sensor_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_async,
  input  logic [1:0] edge_sel,
  output logic       irq_pulse
);
  localparam int unsigned STAGES_USED =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic       lvl_sync;
  logic       lvl_ok;
  logic       lvl_prev;
  edge_mode_e mode;

  assign mode = edge_mode_e'(edge_sel);

  sensor_evt_sync #(
    .STAGES (STAGES_USED)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (evt_async),
    .q_sync  (lvl_sync),
    .q_ok    (lvl_ok)
  );

  sensor_evt_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl_sync),
    .lvl_ok   (lvl_ok),
    .mode     (mode),
    .lvl_prev (lvl_prev),
    .pulse    (irq_pulse)
  );

endmodule

// File: rtl/sensor_evt_irq_chk.sv
module sensor_evt_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] edge_sel,
  input logic       irq,
  input logic       lvl,
  input logic       lvl_q
);
  // R1: a cycle in reset leaves the request low on the next cycle.
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !irq);

  // R5: the off mode never lets a request through.
  assert_off_mode_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(edge_sel) != 2'b00);

  // R2: a request in rising mode follows a low-to-high synchronized change.
  assert_rise_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(edge_sel) == 2'b01) |-> ($past(lvl) && !$past(lvl_q)));

  // R3: a request in falling mode follows a high-to-low synchronized change.
  assert_fall_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(edge_sel) == 2'b10) |-> (!$past(lvl) && $past(lvl_q)));

  // R7: with the synchronized level unchanged, no request is raised.
  assert_steady_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lvl) == $past(lvl_q)) |-> !irq);

endmodule

bind sensor_evt_irq sensor_evt_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .edge_sel (edge_sel),
  .irq      (irq_pulse),
  .lvl      (lvl_sync),
  .lvl_q    (lvl_prev)
);

// File: tb/test_sensor_evt_irq.sv
`timescale 1ns/1ps
module test_sensor_evt_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_async = 1'b0;
  logic [1:0] edge_sel = 2'b00;
  logic       irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sensor_evt_irq i_sensor_evt_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_async (evt_async),
    .edge_sel  (edge_sel),
    .irq_pulse (irq_pulse)
  );

  // Each entry is {mode, expected pulse}; the event line toggles once per entry, starting from 0.
  localparam logic [2:0] VEC [8] = '{
    {2'b01, 1'b1}, {2'b01, 1'b0},
    {2'b10, 1'b0}, {2'b10, 1'b1},
    {2'b11, 1'b1}, {2'b11, 1'b1},
    {2'b00, 1'b0}, {2'b00, 1'b0}
  };

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b01:   return "R2";
      2'b10:   return "R3";
      2'b11:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts pulses over n cycles, sampled at negedges; 'first' is the 1-based index of the first pulse.
  task automatic observe(input int n, output int cnt, output int first, output int second);
    cnt = 0; first = 0; second = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq_pulse) begin
        cnt++;
        if (first == 0) first = i;
        else if (second == 0) second = i;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt, first, second;

    // R1: event already high through reset, both edges enabled.
    evt_async = 1'b1;
    edge_sel  = 2'b11;
    repeat (3) @(negedge clk);
    check("R1 during reset", irq_pulse, 0);
    rst_n = 1'b1;
    observe(10, cnt, first, second);
    check("R1 pulses after release with high level", cnt, 0);

    // Return to low with rising mode only, which must stay silent.
    edge_sel = 2'b01;
    @(negedge clk);
    evt_async = 1'b0;
    observe(8, cnt, first, second);
    check("R2 fall ignored in rising mode", cnt, 0);

    // Vector walk: one toggle per entry.
    for (int k = 0; k < 8; k++) begin
      edge_sel = VEC[k][2:1];
      repeat (3) @(negedge clk);
      evt_async = ~evt_async;
      observe(8, cnt, first, second);
      check(tag_of(VEC[k][2:1]), cnt, int'(VEC[k][0]));
      if (VEC[k][0]) check("R6 pulse cycle", first, 3);
    end

    // R7: long steady level after a rising edge under both-mode.
    edge_sel = 2'b11;
    @(negedge clk);
    evt_async = 1'b1;
    observe(8, cnt, first, second);
    check("R4 rising pulse", cnt, 1);
    observe(40, cnt, first, second);
    check("R7 pulses during steady high", cnt, 0);
    evt_async = 1'b0;
    observe(8, cnt, first, second);
    check("R4 falling pulse", cnt, 1);
    observe(40, cnt, first, second);
    check("R7 pulses during steady low", cnt, 0);

    // R8: two-cycle high pulse on the event line.
    @(negedge clk);
    evt_async = 1'b1;
    @(negedge clk);
    @(negedge clk);
    evt_async = 1'b0;
    // Two cycles have already elapsed since the rise was driven.
    observe(10, cnt, first, second);
    check("R8 pulse count", cnt, 2);
    check("R8 first pulse cycle", first + 2, 3);
    check("R8 second pulse cycle", second + 2, 5);

    // R6: pulse lasts one cycle (it is gone by the next sample).
    evt_async = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check("R6 pulse high", irq_pulse, 1);
    @(posedge clk); @(negedge clk);
    check("R6 pulse width one cycle", irq_pulse, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule